// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Sequencer

This block drives one conversion-and-read cycle at a time on an external 12-bit successive-approximation converter with a parallel output bus. A start request pulls the active-low convert strobe down. The sequencer then ignores the busy flag for a blanking window, because busy may not yet have risen. After that window it waits for busy to drop. It then asserts chip-select and read together, samples the data bus late in the read pulse, releases read, and releases chip-select one cycle later. A quiet interval must pass before the next conversion may begin.

Every strobe width and gap is set in nanoseconds and converted to whole system-clock cycles by ceiling division of the clock-period parameter. Busy passes through a parameterised synchronizer. A start that arrives while a cycle is running is remembered and served once the quiet interval has elapsed. If busy stays high too long, a sticky error flag is set and the sequencer returns to idle. As an option, the block can also generate the converter's conversion clock. This clock runs only during the conversion phase, with its first edge delayed past the convert strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Each conversion holds `cnv_strb_n` low for exactly ceil(T_CONV_LOW_NS / CLK_PERIOD_NS) cycles, which is 3 cycles at the defaults.
- R2: `conv_busy` is ignored during a blanking window. With busy held low throughout, `chip_sel_n` falls exactly max(ceil(10/P), ceil(35/P) + BUSY_SYNC) + 1 cycles after `cnv_strb_n` falls, which is 12 cycles at P = 4 ns with two synchronizer stages.
- R3: After the blanking window, `chip_sel_n` and `read_n` fall (0 = asserted) exactly BUSY_SYNC + 1 cycles after `conv_busy` falls, and never while busy is still high.
- R4: `read_n` stays low for exactly max(ceil(20/P), ceil(15/P) + 1) cycles, which is 5 cycles at the defaults. `chip_sel_n` is low whenever `read_n` is low, stays low for the one cycle after `read_n` rises, and is high in the cycle after that.
- R5: `sample_data` equals the value on `bus_data` during the last low cycle of `read_n`. `sample_vld` is 1 for exactly one cycle, the cycle right after `read_n` rises.
- R6: The next falling edge of `cnv_strb_n` comes no sooner than ceil(T_QUIET_NS / P) cycles after `read_n` rises. With a start already pending, it comes exactly ceil(T_QUIET_NS / P) + 1 cycles after, which is 26 cycles at the defaults.
- R7: A `start` pulse that arrives while a cycle is running is kept, and it launches the next conversion with no further request.
- R8: If `conv_busy` is still high BUSY_TIMEOUT_CYC cycles after the busy wait begins, `timeout_err` becomes 1 and the sequencer returns to idle. No read and no sample take place. The flag stays 1 until reset, and later conversions run normally.
- R9: With GEN_ADC_CLK = 1, `adc_clk` toggles with ADC_CLK_HALF cycles high and ADC_CLK_HALF cycles low. Its first rise comes at least ceil(T_CLK_LEAD_NS / P) cycles after `cnv_strb_n` falls, and it rests low while idle. Elaboration rejects a setting that would make `adc_clk` faster than 30 MHz or slower than 10 kHz.
- R10: During and right after reset, `cnv_strb_n`, `chip_sel_n` and `read_n` are 1, and `adc_clk`, `sample_vld` and `timeout_err` are 0.
- R11: In idle, `cnv_strb_n` goes low on the same clock edge that first samples `start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled each cycle |
| conv_busy | input | 1 | Converter busy flag, asynchronous |
| bus_data | input | DATA_W | Converter parallel data bus |
| cnv_strb_n | output | 1 | Active-low convert strobe |
| chip_sel_n | output | 1 | Active-low chip select |
| read_n | output | 1 | Active-low read strobe |
| adc_clk | output | 1 | Optional conversion clock for the converter |
| sample_vld | output | 1 | One-cycle pulse marking a new sample |
| sample_data | output | DATA_W | Last captured sample |
| timeout_err | output | 1 | Sticky busy-timeout flag |

## Verification
The bench builds the block with a 4 ns period, two busy synchronizer stages, the converter clock enabled with a 5-cycle half period, and the busy timeout shortened to 40 cycles. The short timeout lets the error path, its stickiness and the recovery afterwards all fit in one short run. The 4 ns period rounds every interval to a distinct non-trivial cycle count: 3, 9, 4, 5 and 25. Because of this, a mistake in the rounding or the blanking shows up as a wrong width, latency or quiet gap at the ports. Junk data is held on the bus until the final read cycles, so an early capture point is caught.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CONV,
      S_BWAIT,
      S_READ,
      S_HOLD,
      S_QUIET
   } seq_state_e;

   // ceiling division of a nanosecond interval by the clock period
   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adcseq_sync.sv
`timescale 1ns/1ps
module adcseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         logic unused_sync;
         assign unused_sync = clk ^ rst_n;
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adcseq_capture.sv
`timescale 1ns/1ps
module adcseq_capture #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          vld
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         vld  <= 1'b0;
      end else begin
         vld <= take;
         if (take) dout <= din;
      end
   end

endmodule

// File: rtl/adcseq_clkgen.sv
`timescale 1ns/1ps
module adcseq_clkgen #(
   parameter int GEN  = 1,
   parameter int HALF = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic aclk
);

   generate
      if (GEN != 0) begin : g_gen
         localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
         logic [DIV_W-1:0] div;
         logic             ck;

         // a high phase always completes, so no runt pulse on disable
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div <= '0;
               ck  <= 1'b0;
            end else if (en || ck) begin
               if (div == DIV_LAST) begin
                  div <= '0;
                  ck  <= ~ck;
               end else begin
                  div <= div + 1'b1;
               end
            end else begin
               div <= '0;
            end
         end
         assign aclk = ck;
      end else begin : g_off
         logic unused_clkgen;
         assign unused_clkgen = clk ^ rst_n ^ en;
         assign aclk = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
   import adcseq_pkg::*;
#(
   parameter int DATA_W           = 12,
   parameter int CLK_PERIOD_NS    = 4,
   parameter int T_CONV_LOW_NS    = 10,
   parameter int T_BUSY_DLY_NS    = 35,
   parameter int T_RD_LOW_NS      = 20,
   parameter int T_ACCESS_NS      = 15,
   parameter int T_QUIET_NS       = 100,
   parameter int T_CLK_LEAD_NS    = 10,
   parameter int BUSY_SYNC        = 2,
   parameter int BUSY_TIMEOUT_CYC = 256,
   parameter int GEN_ADC_CLK      = 1,
   parameter int ADC_CLK_HALF     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              conv_busy,
   input  logic [DATA_W-1:0] bus_data,
   output logic              cnv_strb_n,
   output logic              chip_sel_n,
   output logic              read_n,
   output logic              adc_clk,
   output logic              sample_vld,
   output logic [DATA_W-1:0] sample_data,
   output logic              timeout_err
);

   // ---- interval derivation ------------------------------------------
   localparam int CONV_CYC  = cdiv(T_CONV_LOW_NS, CLK_PERIOD_NS);
   localparam int BLANK_CYC = cdiv(T_BUSY_DLY_NS, CLK_PERIOD_NS);
   localparam int RD_CYC    = cdiv(T_RD_LOW_NS, CLK_PERIOD_NS);
   localparam int ACC_CYC   = cdiv(T_ACCESS_NS, CLK_PERIOD_NS);
   localparam int RDLOW_CYC = imax(RD_CYC, ACC_CYC + 1);
   localparam int QUIET_RAW = cdiv(T_QUIET_NS, CLK_PERIOD_NS);
   localparam int QUIET_CYC = imax(QUIET_RAW, 2);
   localparam int LEAD_CYC  = cdiv(T_CLK_LEAD_NS, CLK_PERIOD_NS);
   localparam int CONV_SPAN = imax(CONV_CYC, BLANK_CYC + BUSY_SYNC);
   localparam int CNT_MAX   = imax(imax(CONV_SPAN, BUSY_TIMEOUT_CYC),
                                   imax(imax(RDLOW_CYC, QUIET_CYC), LEAD_CYC));
   localparam int CNT_W     = $clog2(CNT_MAX + 1);

   localparam logic [CNT_W-1:0] K_CONV_END = CNT_W'(CONV_CYC - 1);
   localparam logic [CNT_W-1:0] K_SPAN_END = CNT_W'(CONV_SPAN - 1);
   localparam logic [CNT_W-1:0] K_TO_END   = CNT_W'(BUSY_TIMEOUT_CYC - 1);
   localparam logic [CNT_W-1:0] K_RD_END   = CNT_W'(RDLOW_CYC - 1);
   localparam logic [CNT_W-1:0] K_QT_END   = CNT_W'(QUIET_CYC - 2);
   localparam logic [CNT_W-1:0] K_LEAD     = CNT_W'(LEAD_CYC);

   // ---- elaboration-time parameter checks ----------------------------
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be at least 1");
      end
      if (BUSY_SYNC < 0 || BUSY_SYNC > 4) begin : g_bad_sync
         $error("BUSY_SYNC must lie in 0..4");
      end
      if (BUSY_TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("BUSY_TIMEOUT_CYC must be at least 1");
      end
      if (GEN_ADC_CLK != 0) begin : g_clk_chk
         if (ADC_CLK_HALF < 1) begin : g_bad_half
            $error("ADC_CLK_HALF must be at least 1");
         end
         if (2 * ADC_CLK_HALF * CLK_PERIOD_NS * 30 < 1000) begin : g_too_fast
            $error("converter clock would exceed 30 MHz");
         end
         if (2 * ADC_CLK_HALF * CLK_PERIOD_NS > 100000) begin : g_too_slow
            $error("converter clock would fall below 10 kHz");
         end
      end
   endgenerate

   // ---- busy synchronizer ---------------------------------------------
   logic busy_s;

   adcseq_sync #(.STAGES(BUSY_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (conv_busy),
      .q     (busy_s)
   );

   // ---- sequencer -----------------------------------------------------
   seq_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic             take;
   logic             clk_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         cnt         <= '0;
         pend        <= 1'b0;
         cnv_strb_n  <= 1'b1;
         chip_sel_n  <= 1'b1;
         read_n      <= 1'b1;
         timeout_err <= 1'b0;
      end else begin
         if (start && state != S_IDLE) pend <= 1'b1;
         case (state)
            S_IDLE: begin
               if (start || pend) begin
                  state      <= S_CONV;
                  cnt        <= '0;
                  cnv_strb_n <= 1'b0;
                  pend       <= 1'b0;
               end
            end
            S_CONV: begin
               if (cnt == K_CONV_END) cnv_strb_n <= 1'b1;
               if (cnt == K_SPAN_END) begin
                  state <= S_BWAIT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_BWAIT: begin
               if (!busy_s) begin
                  state      <= S_READ;
                  cnt        <= '0;
                  chip_sel_n <= 1'b0;
                  read_n     <= 1'b0;
               end else if (cnt == K_TO_END) begin
                  timeout_err <= 1'b1;
                  state       <= S_IDLE;
                  cnt         <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_READ: begin
               if (cnt == K_RD_END) begin
                  read_n <= 1'b1;
                  state  <= S_HOLD;
                  cnt    <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_HOLD: begin
               chip_sel_n <= 1'b1;
               state      <= S_QUIET;
               cnt        <= '0;
            end
            S_QUIET: begin
               if (cnt == K_QT_END) state <= S_IDLE;
               else                 cnt   <= cnt + 1'b1;
            end
            default: begin
               state <= S_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign take   = (state == S_READ) && (cnt == K_RD_END);
   assign clk_en = ((state == S_CONV) && (cnt >= K_LEAD)) || (state == S_BWAIT);

   // ---- capture register ------------------------------------------------
   adcseq_capture #(.DW(DATA_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .din   (bus_data),
      .dout  (sample_data),
      .vld   (sample_vld)
   );

   // ---- optional converter clock -------------------------------------
   adcseq_clkgen #(.GEN(GEN_ADC_CLK), .HALF(ADC_CLK_HALF)) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (clk_en),
      .aclk  (adc_clk)
   );

endmodule

// File: rtl/adcseq_chk.sv
`timescale 1ns/1ps
module adcseq_chk #(
   parameter int CONV_CYC  = 3,
   parameter int RDLOW_CYC = 5,
   parameter int QUIET_CYC = 25,
   parameter int BLANK_CYC = 9,
   parameter int CLK_HALF  = 5
) (
   input logic clk,
   input logic rst_n,
   input logic strb_n,
   input logic sel_n,
   input logic rd_n,
   input logic busy,
   input logic vld,
   input logic err,
   input logic aclk
);

   logic [15:0] lo_run, rd_run, since_cnv, since_rd, hi_run;
   logic        strb_q, rd_q;

   function automatic logic [15:0] sat(input logic [15:0] x);
      return (x == 16'hFFFF) ? x : x + 16'd1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run    <= '0;
         rd_run    <= '0;
         since_cnv <= '1;
         since_rd  <= '1;
         hi_run    <= '0;
         strb_q    <= 1'b1;
         rd_q      <= 1'b1;
      end else begin
         lo_run    <= !strb_n ? sat(lo_run) : 16'd0;
         rd_run    <= !rd_n ? sat(rd_run) : 16'd0;
         since_cnv <= (!strb_n && strb_q) ? 16'd1 : sat(since_cnv);
         since_rd  <= (rd_n && !rd_q) ? 16'd1 : sat(since_rd);
         hi_run    <= aclk ? sat(hi_run) : 16'd0;
         strb_q    <= strb_n;
         rd_q      <= rd_n;
      end
   end

   a_r1_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_n) |-> lo_run == 16'(CONV_CYC));

   a_r2_blanking: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n) |-> since_cnv >= 16'(BLANK_CYC));

   a_r3_sel_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n) |-> !$past(busy));

   a_r4_read_inside_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !sel_n);

   a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> !sel_n);

   a_r4_read_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> rd_run == 16'(RDLOW_CYC));

   a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld);

   a_r6_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_n) |-> since_rd >= 16'(QUIET_CYC));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   a_r9_clk_high_half: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(aclk) |-> hi_run == 16'(CLK_HALF));

endmodule

bind adc_seq_ctrl adcseq_chk #(
   .CONV_CYC  (CONV_CYC),
   .RDLOW_CYC (RDLOW_CYC),
   .QUIET_CYC (QUIET_RAW),
   .BLANK_CYC (BLANK_CYC),
   .CLK_HALF  (ADC_CLK_HALF)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .strb_n (cnv_strb_n),
   .sel_n  (chip_sel_n),
   .rd_n   (read_n),
   .busy   (conv_busy),
   .vld    (sample_vld),
   .err    (timeout_err),
   .aclk   (adc_clk)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

   localparam int DW   = 12;
   localparam int PER  = 4;
   localparam int TO   = 40;
   localparam int SYNC = 2;
   localparam int HALF = 5;

   function automatic int cd(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   localparam int E_CONV  = cd(10, PER);
   localparam int E_RDA   = cd(20, PER);
   localparam int E_RDB   = cd(15, PER) + 1;
   localparam int E_RD    = (E_RDA > E_RDB) ? E_RDA : E_RDB;
   localparam int E_QUIET = cd(100, PER);
   localparam int E_BLK   = cd(35, PER) + SYNC;
   localparam int E_BLAT  = ((E_BLK > E_CONV) ? E_BLK : E_CONV) + 1;
   localparam int E_LEAD  = cd(10, PER);

   // {busy high cycles after strobe rises [19:12], bus value [11:0]}
   localparam logic [19:0] VEC [0:5] = '{
      20'h08A5C, 20'h0C000, 20'h14FFF, 20'h095A3, 20'h1E801, 20'h0F3C7
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          conv_busy = 1'b0;
   logic [DW-1:0] bus_data = '0;
   logic          cnv_strb_n, chip_sel_n, read_n, adc_clk, sample_vld, timeout_err;
   logic [DW-1:0] sample_data;

   int n_chk = 0;
   int n_bad = 0;
   int vld_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   adc_seq_ctrl #(
      .CLK_PERIOD_NS    (PER),
      .BUSY_SYNC        (SYNC),
      .BUSY_TIMEOUT_CYC (TO),
      .GEN_ADC_CLK      (1),
      .ADC_CLK_HALF     (HALF)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .conv_busy   (conv_busy),
      .bus_data    (bus_data),
      .cnv_strb_n  (cnv_strb_n),
      .chip_sel_n  (chip_sel_n),
      .read_n      (read_n),
      .adc_clk     (adc_clk),
      .sample_vld  (sample_vld),
      .sample_data (sample_data),
      .timeout_err (timeout_err)
   );

   always @(negedge clk) if (sample_vld) vld_seen++;

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_ge(input string tag, input int act, input int lim);
      n_chk++;
      if (act < lim) begin
         n_bad++;
         $display("FAIL %s act=%0d exp>=%0d", tag, act, lim);
      end
   endtask

   task automatic chk_reset(input string tag);
      chk_eq({tag, " strobe"}, cnv_strb_n, 1);
      chk_eq({tag, " select"}, chip_sel_n, 1);
      chk_eq({tag, " read"}, read_n, 1);
      chk_eq({tag, " adc_clk"}, adc_clk, 0);
      chk_eq({tag, " valid"}, sample_vld, 0);
      chk_eq({tag, " error"}, timeout_err, 0);
   endtask

   // one full conversion handshake; returns in the cycle select releases
   task automatic run_conv(input bit do_start, input bit mid_start,
                           input int bhi, input logic [DW-1:0] val);
      int w;
      if (do_start) begin
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk_eq("R11 strobe falls on start", cnv_strb_n, 0);
      end
      w = 0;
      while (!cnv_strb_n && w < 100) begin
         w++;
         if (w == 1) conv_busy = 1'b1;
         if (mid_start && w == 2) start = 1'b1;
         if (mid_start && w == 3) start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      chk_eq("R1 strobe low width", w, E_CONV);
      repeat (bhi) @(negedge clk);
      conv_busy = 1'b0;
      w = 0;
      while (chip_sel_n && w < 200) begin
         @(negedge clk);
         w++;
      end
      chk_eq("R3 select latency after busy", w, SYNC + 1);
      chk_eq("R4 read falls with select", read_n, 0);
      bus_data = ~val;
      w = 0;
      while (!read_n && w < 200) begin
         w++;
         if (w == E_RD - 1) bus_data = val;
         @(negedge clk);
      end
      chk_eq("R4 read low width", w, E_RD);
      chk_eq("R5 valid after read", sample_vld, 1);
      chk_eq("R5 captured value", sample_data, val);
      chk_eq("R4 select held past read", chip_sel_n, 0);
      bus_data = '0;
      @(negedge clk);
      chk_eq("R5 valid single cycle", sample_vld, 0);
      chk_eq("R4 select released", chip_sel_n, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R10 watchdog act=hung exp=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int w;
      int v0;
      repeat (3) @(negedge clk);
      chk_reset("R10 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset("R10 after reset");

      // table of conversions with varied busy length and data
      for (int i = 0; i < 6; i++) begin
         run_conv(1'b1, 1'b0, int'(VEC[i][19:12]), VEC[i][11:0]);
         repeat (30) @(negedge clk);
      end

      // R2: busy low from the start must not shorten blanking
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      w = 0;
      while (chip_sel_n && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk_eq("R2 blanking latency", w, E_BLAT);
      repeat (40) @(negedge clk);

      // R7 pending request and R6 quiet gap
      run_conv(1'b1, 1'b1, 10, 12'h6B2);
      w = 0;
      while (cnv_strb_n && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk_eq("R7 pending start served", cnv_strb_n, 0);
      chk_eq("R6 quiet gap", w + 1, E_QUIET + 1);
      run_conv(1'b0, 1'b0, 10, 12'h1E4);
      repeat (30) @(negedge clk);

      // R8 busy timeout
      v0 = vld_seen;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      conv_busy = 1'b1;
      repeat (60) @(negedge clk);
      chk_eq("R8 timeout flag", timeout_err, 1);
      chk_eq("R8 select idle", chip_sel_n, 1);
      chk_eq("R8 read idle", read_n, 1);
      chk_eq("R8 no sample", vld_seen, v0);
      conv_busy = 1'b0;
      repeat (5) @(negedge clk);
      run_conv(1'b1, 1'b0, 8, 12'h9D1);
      chk_eq("R8 flag sticky", timeout_err, 1);
      repeat (30) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R10 reset clears error", timeout_err, 0);

      // R9 converter clock
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      conv_busy = 1'b1;
      w = 0;
      while (!adc_clk && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk_ge("R9 first edge lead", w, E_LEAD);
      w = 0;
      while (adc_clk && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk_eq("R9 high half", w, HALF);
      w = 0;
      while (!adc_clk && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk_eq("R9 low half", w, HALF);
      conv_busy = 1'b0;
      repeat (60) @(negedge clk);
      chk_eq("R9 idle clock low", adc_clk, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule